// File: doc/BRIEF.md
# Legacy Access Fallback Mode Controller

This block sits beside a banked UART register file and holds the UART's mode settings. It watches every CPU register access. A read or write of the legacy baud divisor locations in bank 1 tells it that software written for the plain 16550 is running. The block then reverts the UART from its extended features to a compatible state: 16-level FIFOs, a prescaler value of 13 and cleared test bits. If the UART was in extended mode, it also leaves that mode. It keeps any infrared protocol selection and otherwise returns to plain UART protocol.

Drivers that know the extended features program the baud rate through alternate divisor locations in bank 2. Those accesses never cause a reversion. A lock bit turns reversion off while the UART is in non-extended mode. In that state, accesses to the two legacy divisor locations go to two scratch registers instead, and the baud setting stays as it was. Software loads the mode settings with a one-cycle configuration strobe. The control pins are plain level and strobe signals. No data stream passes through the block, so it needs no valid/ready flow control.

Top module: `legacy_fallback_ctl`

## Requirements
- R1: A read strobe or write strobe with `acc_bank`=1 and `acc_addr` equal to 0 (divisor low byte) or 1 (divisor high byte) triggers a fallback, unless R7 applies. The fallback effects appear on the outputs in the cycle after the strobe.
- R2: Accesses with `acc_bank`=2 never trigger a fallback, and neither do accesses to any other bank/offset pair outside R1. The state outputs keep their values.
- R3: A fallback drives `fifo_deep` to 0 (16-level FIFOs), `prescale` to 13, and `baud_test` and `loop_test` to 0.
- R4: A fallback that starts with `ext_mode`=1 clears `ext_mode`. It also sets `proto_mode` to 0 (UART), except when `proto_mode` is 1 (SIR) or 2 (Sharp-IR), in which case `proto_mode` is kept.
- R5: A fallback that starts with `ext_mode`=0 leaves `ext_mode` and `proto_mode` unchanged.
- R6: With `ext_mode`=1, the lock bit has no effect, and R1 accesses always trigger a fallback.
- R7: With `lock`=1 and `ext_mode`=0, R1 accesses do not trigger a fallback and the state outputs are unchanged. `div_redirect` is high in the same cycle as the access. A write stores `acc_wdata` in scratch register 0 (offset 0) or scratch register 1 (offset 1). A read returns that register's last written value on `scr_rdata` in the same cycle. At all other times `scr_rdata` is 0.
- R8: After reset: `ext_mode`=0, `proto_mode`=0, `lock`=0, `fifo_deep`=0, `prescale`=13, `baud_test`=0, `loop_test`=0, and both scratch registers hold 0.
- R9: A `cfg_load` pulse copies the `cfg_*` inputs to the state outputs in the next cycle. If a fallback triggers in the same cycle, the fallback wins and that `cfg_load` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | CPU read strobe |
| acc_wr | input | 1 | CPU write strobe |
| acc_bank | input | 2 | Currently selected register bank |
| acc_addr | input | 3 | Register offset within the bank |
| acc_wdata | input | 8 | CPU write data |
| cfg_load | input | 1 | Load strobe for the cfg_* values |
| cfg_ext | input | 1 | Extended mode value to load |
| cfg_proto | input | 3 | Protocol mode to load (0 UART, 1 SIR, 2 Sharp-IR, others) |
| cfg_lock | input | 1 | Lock bit to load |
| cfg_fifo_deep | input | 1 | FIFO depth select to load (0 = 16 levels) |
| cfg_prescale | input | 5 | Prescaler value to load |
| cfg_baud_test | input | 1 | Baud test bit to load |
| cfg_loop_test | input | 1 | Loopback test bit to load |
| ext_mode | output | 1 | Extended mode active |
| proto_mode | output | 3 | Protocol mode |
| lock | output | 1 | Fallback lock bit |
| fifo_deep | output | 1 | FIFO depth select |
| prescale | output | 5 | Baud prescaler value |
| baud_test | output | 1 | Baud generator test bit |
| loop_test | output | 1 | Loopback test bit |
| div_redirect | output | 1 | Current access is served by the scratch overlay |
| scr_rdata | output | 8 | Scratch overlay read data |

## Verification
The redirect flag and the scratch read data are combinational, so they are due in the same cycle as the access. The bench samples them shortly after it drives the access, away from any clock edge. The fallback effects, the configuration load and the scratch writes are registered and are due one cycle after the strobe. The bench drops the strobe at the next falling edge and checks the state outputs there, after exactly one rising edge. Scratch contents are checked by later redirected reads. The sweep covers every bank, offset, strobe type, extended mode, lock value and protocol code.

// File: rtl/fbk_pkg.sv
package fbk_pkg;
  localparam logic [2:0] PROTO_UART = 3'd0;
  localparam logic [2:0] PROTO_SIR  = 3'd1;
  localparam logic [2:0] PROTO_SHIR = 3'd2;

  typedef struct packed {
    logic       ext;
    logic [2:0] proto;
    logic       lock;
    logic       fifo_deep;
    logic       btest;
    logic       lbtest;
  } ctl_t;
endpackage

// File: rtl/fbk_decode.sv
module fbk_decode #(
  parameter int ADDR_W      = 3,
  parameter int BANK_W      = 2,
  parameter int LEGACY_BANK = 1,
  parameter int DIV_LO_OFS  = 0,
  parameter int DIV_HI_OFS  = 1
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext,
  input  logic              lock,
  output logic              trig,
  output logic              redirect,
  output logic              sel_hi
);
  logic hit, locked;

  always_comb begin
    hit      = (rd | wr) && (bank == BANK_W'(LEGACY_BANK)) &&
               ((addr == ADDR_W'(DIV_LO_OFS)) || (addr == ADDR_W'(DIV_HI_OFS)));
    locked   = lock && !ext;
    trig     = hit && !locked;
    redirect = hit && locked;
    sel_hi   = (addr == ADDR_W'(DIV_HI_OFS));
  end
endmodule

// File: rtl/fbk_overlay.sv
module fbk_overlay #(
  parameter int DATA_W  = 8,
  parameter int NUM_SCR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect,
  input  logic              rd,
  input  logic              wr,
  input  logic              sel_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] scr [NUM_SCR];

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    logic pick;
    assign pick = (g == 0) ? !sel_hi : sel_hi;
    always_ff @(posedge clk) begin
      if (!rst_n)                    scr[g] <= '0;
      else if (redirect && wr && pick) scr[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (redirect && rd) rdata = sel_hi ? scr[1] : scr[0];
  end

  p_scr_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && wr && !sel_hi) |=> scr[0] == $past(wdata));
  p_scr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect && rd) |-> rdata == '0);
endmodule

// File: rtl/fbk_state.sv
module fbk_state
  import fbk_pkg::*;
#(
  parameter int PSC_W  = 5,
  parameter int PSC_FB = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             cfg_load,
  input  ctl_t             cfg,
  input  logic [PSC_W-1:0] cfg_psc,
  output ctl_t             st,
  output logic [PSC_W-1:0] psc
);
  localparam logic [PSC_W-1:0] PscFb = PSC_W'(PSC_FB);

  ctl_t             st_q;
  logic [PSC_W-1:0] psc_q;
  logic             ir_keep;

  assign ir_keep = (st_q.proto == PROTO_SIR) || (st_q.proto == PROTO_SHIR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '{ext: 1'b0, proto: PROTO_UART, lock: 1'b0,
                 fifo_deep: 1'b0, btest: 1'b0, lbtest: 1'b0};
      psc_q <= PscFb;
    end else if (trig) begin
      st_q.fifo_deep <= 1'b0;
      st_q.btest     <= 1'b0;
      st_q.lbtest    <= 1'b0;
      psc_q          <= PscFb;
      if (st_q.ext) begin
        st_q.ext <= 1'b0;
        if (!ir_keep) st_q.proto <= PROTO_UART;
      end
    end else if (cfg_load) begin
      st_q  <= cfg;
      psc_q <= cfg_psc;
    end
  end

  assign st  = st_q;
  assign psc = psc_q;

  p_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (psc_q == PscFb) && !st_q.fifo_deep && !st_q.btest && !st_q.lbtest);
  p_ext_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && st_q.ext) |=> !st_q.ext);
  p_ir_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && st_q.ext && ir_keep) |=> st_q.proto == $past(st_q.proto));
  p_uart_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && st_q.ext && !ir_keep) |=> st_q.proto == PROTO_UART);
  p_nonext_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !st_q.ext) |=> !st_q.ext && st_q.proto == $past(st_q.proto));
  p_cfg_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && cfg_load) |=> st_q.lock == $past(st_q.lock));
endmodule

// File: rtl/legacy_fallback_ctl.sv
module legacy_fallback_ctl
  import fbk_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int BANK_W      = 2,
  parameter int DATA_W      = 8,
  parameter int PSC_W       = 5,
  parameter int PSC_FB      = 13,
  parameter int LEGACY_BANK = 1,
  parameter int ALT_BANK    = 2,
  parameter int DIV_LO_OFS  = 0,
  parameter int DIV_HI_OFS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              cfg_load,
  input  logic              cfg_ext,
  input  logic [2:0]        cfg_proto,
  input  logic              cfg_lock,
  input  logic              cfg_fifo_deep,
  input  logic [PSC_W-1:0]  cfg_prescale,
  input  logic              cfg_baud_test,
  input  logic              cfg_loop_test,
  output logic              ext_mode,
  output logic [2:0]        proto_mode,
  output logic              lock,
  output logic              fifo_deep,
  output logic [PSC_W-1:0]  prescale,
  output logic              baud_test,
  output logic              loop_test,
  output logic              div_redirect,
  output logic [DATA_W-1:0] scr_rdata
);
  localparam int NUM_SCR = 2;

  ctl_t cfg_s, st_s;
  logic trig, redirect, sel_hi;

  assign cfg_s = '{ext: cfg_ext, proto: cfg_proto, lock: cfg_lock,
                   fifo_deep: cfg_fifo_deep, btest: cfg_baud_test,
                   lbtest: cfg_loop_test};

  fbk_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .LEGACY_BANK(LEGACY_BANK),
    .DIV_LO_OFS(DIV_LO_OFS), .DIV_HI_OFS(DIV_HI_OFS)
  ) u_dec (
    .rd(acc_rd), .wr(acc_wr), .bank(acc_bank), .addr(acc_addr),
    .ext(st_s.ext), .lock(st_s.lock),
    .trig(trig), .redirect(redirect), .sel_hi(sel_hi)
  );

  fbk_state #(.PSC_W(PSC_W), .PSC_FB(PSC_FB)) u_st (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_load(cfg_load),
    .cfg(cfg_s), .cfg_psc(cfg_prescale), .st(st_s), .psc(prescale)
  );

  fbk_overlay #(.DATA_W(DATA_W), .NUM_SCR(NUM_SCR)) u_ov (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .rd(acc_rd), .wr(acc_wr),
    .sel_hi(sel_hi), .wdata(acc_wdata), .rdata(scr_rdata)
  );

  assign ext_mode     = st_s.ext;
  assign proto_mode   = st_s.proto;
  assign lock         = st_s.lock;
  assign fifo_deep    = st_s.fifo_deep;
  assign baud_test    = st_s.btest;
  assign loop_test    = st_s.lbtest;
  assign div_redirect = redirect;

  p_alt_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && acc_bank == BANK_W'(ALT_BANK) && !cfg_load)
    |=> $stable(ext_mode) && $stable(prescale) && $stable(fifo_deep));
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_redirect && !cfg_load) |=> $stable(prescale) && $stable(proto_mode));
  p_ext_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> !div_redirect);
endmodule

// File: tb/sim_legacy_fallback_ctl.sv
module sim_legacy_fallback_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       acc_rd = 0, acc_wr = 0;
  logic [1:0] acc_bank = 0;
  logic [2:0] acc_addr = 0;
  logic [7:0] acc_wdata = 0;
  logic       cfg_load = 0, cfg_ext = 0, cfg_lock = 0, cfg_fifo_deep = 0;
  logic       cfg_baud_test = 0, cfg_loop_test = 0;
  logic [2:0] cfg_proto = 0;
  logic [4:0] cfg_prescale = 0;
  logic       ext_mode, lock, fifo_deep, baud_test, loop_test, div_redirect;
  logic [2:0] proto_mode;
  logic [4:0] prescale;
  logic [7:0] scr_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_scr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_fallback_ctl u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] pack_st();
    return {ext_mode, proto_mode, lock, fifo_deep, prescale, baud_test, loop_test};
  endfunction

  task automatic load(input logic e, input logic [2:0] p, input logic l);
    @(negedge clk);
    cfg_load = 1; cfg_ext = e; cfg_proto = p; cfg_lock = l;
    cfg_fifo_deep = 1; cfg_prescale = 5'd7; cfg_baud_test = 1; cfg_loop_test = 1;
    @(negedge clk);
    cfg_load = 0;
    #1 chk("R9 load", pack_st(), {e, p, l, 1'b1, 5'd7, 1'b1, 1'b1});
  endtask

  task automatic access(input logic w, input logic [1:0] b, input logic [2:0] a,
                        input logic [7:0] d);
    acc_rd = !w; acc_wr = w; acc_bank = b; acc_addr = a; acc_wdata = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_scr[0] = 0; m_scr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R8 reset state", pack_st(), {1'b0, 3'd0, 1'b0, 1'b0, 5'd13, 1'b0, 1'b0});
    chk("R8 reset redirect", div_redirect, 0);
    chk("R8 reset rdata", scr_rdata, 0);

    // Full sweep: bank, offset, strobe type, ext, lock, protocol code.
    for (int e = 0; e < 2; e++)
      for (int l = 0; l < 2; l++)
        for (int p = 0; p < 8; p++)
          for (int b = 0; b < 4; b++)
            for (int a = 0; a < 8; a++)
              for (int w = 0; w < 2; w++) begin
                logic hit, locked, trg, red;
                logic [7:0] d, exp_rd;
                logic [2:0] exp_p;
                logic exp_e;
                string tg;
                d      = 8'(p * 37 + b * 11 + a * 5 + w + e * 3 + l * 7);
                hit    = (b == 1) && (a < 2);
                locked = l[0] && !e[0];
                trg    = hit && !locked;
                red    = hit && locked;
                load(e[0], 3'(p), l[0]);
                @(negedge clk);
                access(w[0], 2'(b), 3'(a), d);
                exp_rd = (red && !w[0]) ? m_scr[a[0]] : 8'h00;
                #1;
                chk("R7 redirect", div_redirect, red);
                chk("R7 scratch read", scr_rdata, exp_rd);
                if (red && w[0]) m_scr[a[0]] = d;
                @(negedge clk);
                acc_rd = 0; acc_wr = 0;
                #1;
                if (trg) begin
                  exp_e = 0;
                  exp_p = (e[0] && !(p == 1 || p == 2)) ? 3'd0 : 3'(p);
                  tg = e[0] ? (l[0] ? "R6 R4 R3 R1 fallback ext" : "R4 R3 R1 fallback ext")
                            : "R5 R3 R1 fallback nonext";
                  chk(tg, pack_st(), {exp_e, exp_p, l[0], 1'b0, 5'd13, 1'b0, 1'b0});
                end else begin
                  tg = red ? "R7 locked no fallback" : "R2 no fallback";
                  chk(tg, pack_st(), {e[0], 3'(p), l[0], 1'b1, 5'd7, 1'b1, 1'b1});
                end
              end

    // Directed scratch sequence under lock.
    load(1'b0, 3'd4, 1'b1);
    @(negedge clk); access(1, 2'd1, 3'd0, 8'hA5);
    @(negedge clk); access(1, 2'd1, 3'd1, 8'h3C);
    @(negedge clk); access(1, 2'd2, 3'd0, 8'hFF);
    #1 chk("R2 alt bank not redirected", div_redirect, 0);
    @(negedge clk); access(0, 2'd1, 3'd0, 8'h00);
    #1 chk("R7 read low scratch", scr_rdata, 8'hA5);
    @(negedge clk); access(0, 2'd1, 3'd1, 8'h00);
    #1 chk("R7 read high scratch", scr_rdata, 8'h3C);
    @(negedge clk); acc_rd = 0;
    #1 chk("R7 baud unchanged", pack_st(), {1'b0, 3'd4, 1'b1, 1'b1, 5'd7, 1'b1, 1'b1});

    // Fallback and cfg_load in the same cycle: fallback wins.
    load(1'b0, 3'd3, 1'b0);
    @(negedge clk);
    access(0, 2'd1, 3'd1, 8'h00);
    cfg_load = 1; cfg_ext = 1; cfg_proto = 3'd5; cfg_lock = 1;
    cfg_fifo_deep = 1; cfg_prescale = 5'd9; cfg_baud_test = 1; cfg_loop_test = 1;
    @(negedge clk);
    acc_rd = 0; cfg_load = 0;
    #1 chk("R9 fallback beats load", pack_st(),
           {1'b0, 3'd3, 1'b0, 1'b0, 5'd13, 1'b0, 1'b0});

    finish_run();
  end
endmodule